// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the control registers reached by the privileged move-to-control and move-from-control instruction of a 32-bit processor core. The decode stage presents a 12-bit selector with a read or write strobe and, for writes, 32 bits of data. One clock later the block returns the read data or raises an illegal-instruction flag. The parameter `GEN` picks the processor generation (0 to 4 for generations A to E, oldest first). The generation sets which selectors are legal and how the cache control register is masked.

Write data is masked per register before it is stored, and the cache control register is masked again on read. The master and interrupt stack pointers stay coherent with the live A7: the one that is currently active is read from, and written through to, the core's A7. Writes to the cache control, translation control and processor configuration registers pulse side-effect outputs, which the cache, the MMU and the instruction cache act on.

Top module: `ctrl_reg_file`

## Requirements
- R1: Legality by `GEN`, where L is the low 11 bits of the selector. A (0): L < 2. B (1): selector 0x003 is illegal; otherwise L < 4 or selector 0x804 is legal. C (2): L <= 2, or selector 0x803 or 0x804. D (3): selector 0x802 is illegal; otherwise L < 8 is legal. E (4): selectors 0x000 to 0x008, 0x800, 0x801, 0x806, 0x807 and 0x808. Every other selector is illegal.
- R2: An illegal access sets `illegal_o` in the cycle after the strobe. It returns zero read data, changes no register, and pulses no side-effect output. This holds even when the selector's low bits alias a legal register, for example 0x010 in generation E.
- R3: Every result (read data, illegal flag, pulses) is registered and valid for exactly the one cycle after the strobe. In every other cycle these outputs are zero. When `rd_i` and `wr_i` are both high, the access is a write and returns zero read data.
- R4: Selector map: 0x000 and 0x001 are the source and destination function codes; 0x002 is cache control; 0x003 is translation control; 0x004 to 0x007 are the four transparent-translation registers; 0x008 is bus control; 0x800 is the user SP; 0x801 is the vector base; 0x802 is the cache address; 0x803 is the master SP; 0x804 is the interrupt SP; 0x805 is the MMU status; 0x806 and 0x807 are the user and supervisor root pointers; 0x808 is the processor configuration. Write masks: the function codes keep bits 2:0; the transparent-translation registers use 0xFFFFE364; the root pointers use 0xFFFFFE00; bus control uses 0xF0000000; registers without a listed mask store all 32 bits.
- R5: Cache control write and read masks by generation: B 0x0000000F and 0x00000003; C 0x00003F1F and 0x00003313; D 0x80008000 for both; E 0xF8E0E000 and 0xF880E000. A legal write to it pulses `cache_cfg_o`.
- R6: Translation control stores write data masked with 0xFFFE in generation E and with 0xC000 in the others. A legal write to it pulses `mmu_upd_o`.
- R7: Writing the master SP while `m_bit_i` is 1, or the interrupt SP while it is 0, stores the value and also pulses `a7_we_o` with `a7_wdata_o` equal to the write data. Reading the active one of the two returns `a7_i`; reading the inactive one returns its stored value.
- R8: In the processor configuration only bits 6, 1 and 0 are writable. Bit 1 is forced to 1 while `fpu_absent_i` is high. A write that changes bit 1 pulses `icache_flush_o`.
- R9: After reset every register reads zero, except that processor configuration bit 1 reads the value of `fpu_absent_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 12 | Control register selector |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| fpu_absent_i | input | 1 | No floating-point unit fitted |
| m_bit_i | input | 1 | Master/interrupt stack select from the status register |
| a7_i | input | 32 | Live A7 value |
| rdata_o | output | 32 | Read data, valid the cycle after a legal read |
| illegal_o | output | 1 | Illegal-instruction flag |
| cache_cfg_o | output | 1 | Cache control was written |
| mmu_upd_o | output | 1 | Translation control was written |
| icache_flush_o | output | 1 | Instruction-cache flush request |
| a7_we_o | output | 1 | Load live A7 |
| a7_wdata_o | output | 32 | Value for live A7 |

## Verification
All outputs come from one register stage. The read data, the illegal flag and each pulse are therefore due in the cycle after the edge that samples the strobe, and zero in the cycle after that. The bench drives a strobe on a falling edge, drops it on the next falling edge and samples every output at that moment, half a period after the capturing rising edge. A stored value is checked by a read issued as a separate strobe after the write's result has been sampled.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int DW    = 32;
  localparam int SW    = 12;
  localparam int NSLOT = 18;

  // storage slot per selector: low bank 0..8, high bank 9..17
  localparam int S_SFC  = 0;
  localparam int S_DFC  = 1;
  localparam int S_CACR = 2;
  localparam int S_TCR  = 3;
  localparam int S_TT0  = 4;
  localparam int S_TT3  = 7;
  localparam int S_BUS  = 8;
  localparam int HI_OFS = 9;
  localparam int S_MSP  = 12;
  localparam int S_ISP  = 13;
  localparam int S_URP  = 15;
  localparam int S_SRP  = 16;
  localparam int S_PCR  = 17;

  localparam logic [DW-1:0] FC_MASK   = 32'h0000_0007;
  localparam logic [DW-1:0] TT_MASK   = 32'hFFFF_E364;
  localparam logic [DW-1:0] ROOT_MASK = 32'hFFFF_FE00;
  localparam logic [DW-1:0] BUS_MASK  = 32'hF000_0000;
  localparam logic [DW-1:0] PCR_MASK  = 32'h0000_0043;
  localparam int            PCR_FPU   = 1;

  function automatic logic [DW-1:0] cacr_wmask(int gen);
    case (gen)
      1:       return 32'h0000_000F;
      2:       return 32'h0000_3F1F;
      3:       return 32'h8000_8000;
      4:       return 32'hF8E0_E000;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] cacr_rmask(int gen);
    case (gen)
      1:       return 32'h0000_0003;
      2:       return 32'h0000_3313;
      3:       return 32'h8000_8000;
      4:       return 32'hF880_E000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/crf_legal.sv
module crf_legal #(
  parameter int GEN = 4
) (
  input  logic [11:0] sel_i,
  output logic        legal_o
);
  logic [10:0] low;
  assign low = sel_i[10:0];

  generate
    if (GEN == 0) begin : g_a
      assign legal_o = (low < 11'd2);
    end else if (GEN == 1) begin : g_b
      assign legal_o = (sel_i != 12'h003) && ((low < 11'd4) || (sel_i == 12'h804));
    end else if (GEN == 2) begin : g_c
      assign legal_o = (low <= 11'd2) || (sel_i == 12'h803) || (sel_i == 12'h804);
    end else if (GEN == 3) begin : g_d
      assign legal_o = (sel_i != 12'h802) && (low < 11'd8);
    end else begin : g_e
      assign legal_o = (sel_i <= 12'h008) || (sel_i == 12'h800) || (sel_i == 12'h801) ||
                       (sel_i == 12'h806) || (sel_i == 12'h807) || (sel_i == 12'h808);
    end
  endgenerate
endmodule

// File: rtl/crf_mask.sv
module crf_mask
  import crf_pkg::*;
#(
  parameter int GEN = 4,
  parameter int SLW = 5
) (
  input  logic [SLW-1:0] slot_i,
  output logic [DW-1:0]  wmask_o,
  output logic [DW-1:0]  rmask_o
);
  localparam logic [DW-1:0] TCR_MASK = (GEN == 4) ? 32'h0000_FFFE : 32'h0000_C000;
  localparam logic [DW-1:0] CW       = cacr_wmask(GEN);
  localparam logic [DW-1:0] CR       = cacr_rmask(GEN);

  int sl;
  assign sl = int'(slot_i);

  always_comb begin
    wmask_o = '1;
    rmask_o = '1;
    if (sl == S_SFC || sl == S_DFC)       wmask_o = FC_MASK;
    else if (sl == S_CACR) begin
      wmask_o = CW;
      rmask_o = CR;
    end
    else if (sl == S_TCR)                 wmask_o = TCR_MASK;
    else if (sl >= S_TT0 && sl <= S_TT3)  wmask_o = TT_MASK;
    else if (sl == S_BUS)                 wmask_o = BUS_MASK;
    else if (sl == S_URP || sl == S_SRP)  wmask_o = ROOT_MASK;
  end
endmodule

// File: rtl/ctrl_reg_file.sv
module ctrl_reg_file
  import crf_pkg::*;
#(
  parameter int GEN = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] sel_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          fpu_absent_i,
  input  logic          m_bit_i,
  input  logic [DW-1:0] a7_i,
  output logic [DW-1:0] rdata_o,
  output logic          illegal_o,
  output logic          cache_cfg_o,
  output logic          mmu_upd_o,
  output logic          icache_flush_o,
  output logic          a7_we_o,
  output logic [DW-1:0] a7_wdata_o
);
  localparam int SLW = $clog2(NSLOT);

  logic           legal;
  logic [SLW-1:0] slot, idx;
  logic [DW-1:0]  wmask, rmask;
  logic [DW-1:0]  ctl_q [NSLOT];

  crf_legal #(.GEN(GEN)) u_legal (
    .sel_i   (sel_i),
    .legal_o (legal)
  );

  assign slot = sel_i[SW-1] ? SLW'(sel_i[3:0]) + SLW'(HI_OFS) : SLW'(sel_i[3:0]);
  assign idx  = (int'(slot) < NSLOT) ? slot : '0;

  crf_mask #(.GEN(GEN), .SLW(SLW)) u_mask (
    .slot_i  (idx),
    .wmask_o (wmask),
    .rmask_o (rmask)
  );

  logic wr_en, rd_en, bad;
  logic is_pcr, is_msp, is_isp, a7_hit;
  assign wr_en  = wr_i & legal;
  assign rd_en  = rd_i & ~wr_i & legal;
  assign bad    = (rd_i | wr_i) & ~legal;
  assign is_pcr = (idx == SLW'(S_PCR));
  assign is_msp = (idx == SLW'(S_MSP));
  assign is_isp = (idx == SLW'(S_ISP));
  assign a7_hit = (is_msp & m_bit_i) | (is_isp & ~m_bit_i);

  // processor configuration: fpu bit seen as forced while unit absent
  logic [DW-1:0] fpu_force, pcr_old, pcr_new;
  assign fpu_force = fpu_absent_i ? (DW'(1) << PCR_FPU) : '0;
  assign pcr_old   = ctl_q[S_PCR] | fpu_force;
  assign pcr_new   = (ctl_q[S_PCR] & ~PCR_MASK) | (wdata_i & PCR_MASK) | fpu_force;

  logic [DW-1:0] rval;
  always_comb begin
    if (a7_hit)      rval = a7_i;
    else if (is_pcr) rval = pcr_old;
    else             rval = ctl_q[idx] & rmask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSLOT; i++) ctl_q[i] <= '0;
    end else if (wr_en) begin
      if (is_pcr) ctl_q[idx] <= pcr_new;
      else        ctl_q[idx] <= wdata_i & wmask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o        <= '0;
      illegal_o      <= 1'b0;
      cache_cfg_o    <= 1'b0;
      mmu_upd_o      <= 1'b0;
      icache_flush_o <= 1'b0;
      a7_we_o        <= 1'b0;
      a7_wdata_o     <= '0;
    end else begin
      rdata_o        <= rd_en ? rval : '0;
      illegal_o      <= bad;
      cache_cfg_o    <= wr_en & (idx == SLW'(S_CACR));
      mmu_upd_o      <= wr_en & (idx == SLW'(S_TCR));
      icache_flush_o <= wr_en & is_pcr & (pcr_old[PCR_FPU] ^ pcr_new[PCR_FPU]);
      a7_we_o        <= wr_en & a7_hit;
      a7_wdata_o     <= (wr_en & a7_hit) ? wdata_i : '0;
    end
  end
endmodule

// File: rtl/crf_chk.sv
module crf_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [11:0] sel_i,
  input logic        rd_i,
  input logic        wr_i,
  input logic [31:0] wdata_i,
  input logic        m_bit_i,
  input logic [31:0] rdata_o,
  input logic        illegal_o,
  input logic        cache_cfg_o,
  input logic        mmu_upd_o,
  input logic        icache_flush_o,
  input logic        a7_we_o,
  input logic [31:0] a7_wdata_o
);
  AST_ILL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (rdata_o == '0) && !cache_cfg_o && !mmu_upd_o && !icache_flush_o && !a7_we_o); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |=> !illegal_o && (rdata_o == '0) && !cache_cfg_o && !mmu_upd_o &&
                        !icache_flush_o && !a7_we_o); // R3

  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({illegal_o, cache_cfg_o, mmu_upd_o, icache_flush_o, a7_we_o})); // R3

  AST_FC_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && sel_i == 12'h000) |=> (rdata_o[31:3] == '0)); // R4

  AST_CACHE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_cfg_o |-> $past(wr_i) && ($past(sel_i) == 12'h002)); // R5

  AST_MMU_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmu_upd_o |-> $past(wr_i) && ($past(sel_i) == 12'h003)); // R6

  AST_A7_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a7_we_o |-> $past(wr_i) && (a7_wdata_o == $past(wdata_i)) &&
                ((($past(sel_i) == 12'h803) && $past(m_bit_i)) ||
                 (($past(sel_i) == 12'h804) && !$past(m_bit_i)))); // R7

  AST_FLUSH_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    icache_flush_o |-> $past(wr_i) && ($past(sel_i) == 12'h808)); // R8
endmodule

bind ctrl_reg_file crf_chk u_crf_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sel_i          (sel_i),
  .rd_i           (rd_i),
  .wr_i           (wr_i),
  .wdata_i        (wdata_i),
  .m_bit_i        (m_bit_i),
  .rdata_o        (rdata_o),
  .illegal_o      (illegal_o),
  .cache_cfg_o    (cache_cfg_o),
  .mmu_upd_o      (mmu_upd_o),
  .icache_flush_o (icache_flush_o),
  .a7_we_o        (a7_we_o),
  .a7_wdata_o     (a7_wdata_o)
);

// File: tb/test_ctrl_reg_file.sv
`timescale 1ns/1ps
module test_ctrl_reg_file;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // generation E instance
  logic [11:0] e_sel = '0;
  logic        e_rd = 1'b0, e_wr = 1'b0, e_fpu = 1'b0, e_m = 1'b0;
  logic [31:0] e_wd = '0, e_a7 = 32'hE7E7_0000;
  logic [31:0] e_rdata, e_a7wd;
  logic        e_ill, e_cache, e_mmu, e_flush, e_a7we;

  // generation C instance
  logic [11:0] c_sel = '0;
  logic        c_rd = 1'b0, c_wr = 1'b0, c_fpu = 1'b1, c_m = 1'b0;
  logic [31:0] c_wd = '0, c_a7 = 32'hA700_0000;
  logic [31:0] c_rdata, c_a7wd;
  logic        c_ill, c_cache, c_mmu, c_flush, c_a7we;

  ctrl_reg_file #(.GEN(4)) i_ctrl_reg_file (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(e_sel), .rd_i(e_rd), .wr_i(e_wr),
    .wdata_i(e_wd), .fpu_absent_i(e_fpu), .m_bit_i(e_m), .a7_i(e_a7),
    .rdata_o(e_rdata), .illegal_o(e_ill), .cache_cfg_o(e_cache), .mmu_upd_o(e_mmu),
    .icache_flush_o(e_flush), .a7_we_o(e_a7we), .a7_wdata_o(e_a7wd));

  ctrl_reg_file #(.GEN(2)) i_ctrl_reg_file_c (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(c_sel), .rd_i(c_rd), .wr_i(c_wr),
    .wdata_i(c_wd), .fpu_absent_i(c_fpu), .m_bit_i(c_m), .a7_i(c_a7),
    .rdata_o(c_rdata), .illegal_o(c_ill), .cache_cfg_o(c_cache), .mmu_upd_o(c_mmu),
    .icache_flush_o(c_flush), .a7_we_o(c_a7we), .a7_wdata_o(c_a7wd));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive on a falling edge, release on the next; results are then valid
  task automatic xe(input logic w, input logic r, input logic [11:0] s, input logic [31:0] d);
    @(negedge clk);
    e_wr = w; e_rd = r; e_sel = s; e_wd = d;
    @(negedge clk);
    e_wr = 1'b0; e_rd = 1'b0;
  endtask

  task automatic xc(input logic w, input logic r, input logic [11:0] s, input logic [31:0] d);
    @(negedge clk);
    c_wr = w; c_rd = r; c_sel = s; c_wd = d;
    @(negedge clk);
    c_wr = 1'b0; c_rd = 1'b0;
  endtask

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic        rd;
    logic [11:0] sel;
    logic [31:0] wd;
    logic        ill;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{4'd4, 1'b1, 1'b0, 12'h000, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000},
    '{4'd4, 1'b0, 1'b1, 12'h000, 32'h0000_0000, 1'b0, 32'h0000_0007},
    '{4'd4, 1'b1, 1'b0, 12'h004, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000},
    '{4'd4, 1'b0, 1'b1, 12'h004, 32'h0000_0000, 1'b0, 32'hFFFF_E364},
    '{4'd4, 1'b1, 1'b0, 12'h807, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000},
    '{4'd4, 1'b0, 1'b1, 12'h807, 32'h0000_0000, 1'b0, 32'hFFFF_FE00},
    '{4'd4, 1'b1, 1'b0, 12'h008, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000},
    '{4'd4, 1'b0, 1'b1, 12'h008, 32'h0000_0000, 1'b0, 32'hF000_0000},
    '{4'd5, 1'b1, 1'b0, 12'h002, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000},
    '{4'd5, 1'b0, 1'b1, 12'h002, 32'h0000_0000, 1'b0, 32'hF880_E000},
    '{4'd6, 1'b1, 1'b0, 12'h003, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000},
    '{4'd6, 1'b0, 1'b1, 12'h003, 32'h0000_0000, 1'b0, 32'h0000_FFFE},
    '{4'd3, 1'b1, 1'b1, 12'h801, 32'h1234_5678, 1'b0, 32'h0000_0000},
    '{4'd3, 1'b0, 1'b1, 12'h801, 32'h0000_0000, 1'b0, 32'h1234_5678},
    '{4'd1, 1'b0, 1'b1, 12'h802, 32'h0000_0000, 1'b1, 32'h0000_0000},
    '{4'd1, 1'b1, 1'b0, 12'h805, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000},
    '{4'd1, 1'b0, 1'b1, 12'h804, 32'h0000_0000, 1'b1, 32'h0000_0000},
    '{4'd1, 1'b0, 1'b1, 12'h009, 32'h0000_0000, 1'b1, 32'h0000_0000},
    '{4'd1, 1'b0, 1'b1, 12'h800, 32'h0000_0000, 1'b0, 32'h0000_0000},
    '{4'd2, 1'b1, 1'b0, 12'h010, 32'h0000_0000, 1'b1, 32'h0000_0000},
    '{4'd2, 1'b0, 1'b1, 12'h000, 32'h0000_0000, 1'b0, 32'h0000_0007},
    '{4'd8, 1'b1, 1'b0, 12'h808, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000},
    '{4'd8, 1'b0, 1'b1, 12'h808, 32'h0000_0000, 1'b0, 32'h0000_0043},
    '{4'd3, 1'b0, 1'b0, 12'h801, 32'h0000_0000, 1'b0, 32'h0000_0000}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    xe(1'b0, 1'b1, 12'h801, '0); chk("R9 vbr after reset", e_rdata, 32'h0);
    xe(1'b0, 1'b1, 12'h808, '0); chk("R9 pcr after reset", e_rdata, 32'h0);
    xe(1'b0, 1'b1, 12'h002, '0); chk("R9 cacr after reset", e_rdata, 32'h0);
    xc(1'b0, 1'b1, 12'h803, '0); chk("R9 msp after reset", c_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      xe(VECS[i].wr, VECS[i].rd, VECS[i].sel, VECS[i].wd);
      chk($sformatf("R%0d vec %0d illegal", VECS[i].req, i), {31'b0, e_ill}, {31'b0, VECS[i].ill});
      chk($sformatf("R%0d vec %0d rdata", VECS[i].req, i), e_rdata, VECS[i].exp);
    end

    // R8 flush on change of fpu bit (currently 1)
    xe(1'b1, 1'b0, 12'h808, 32'h0); chk("R8 flush on bit1 clear", {31'b0, e_flush}, 32'h1);
    xe(1'b1, 1'b0, 12'h808, 32'h0); chk("R8 no flush without change", {31'b0, e_flush}, 32'h0);
    // R5 / R6 pulses
    xe(1'b1, 1'b0, 12'h002, 32'h0); chk("R5 cache pulse", {31'b0, e_cache}, 32'h1);
    xe(1'b1, 1'b0, 12'h003, 32'h0); chk("R6 mmu pulse", {31'b0, e_mmu}, 32'h1);
    xe(1'b0, 1'b0, 12'h003, 32'h0); chk("R3 mmu quiet next", {31'b0, e_mmu}, 32'h0);
    // R8 / R9 fpu absent forces bit 1
    e_fpu = 1'b1;
    xe(1'b0, 1'b1, 12'h808, '0); chk("R9 pcr bit1 follows fpu absent", e_rdata, 32'h2);
    xe(1'b1, 1'b0, 12'h808, 32'h40); chk("R8 no flush when forced", {31'b0, e_flush}, 32'h0);
    xe(1'b0, 1'b1, 12'h808, '0); chk("R8 pcr forced bit", e_rdata, 32'h42);

    // R7 stack aliasing (generation C)
    c_m = 1'b0;
    xc(1'b1, 1'b0, 12'h804, 32'h1111); chk("R7 isp write loads a7", {31'b0, c_a7we}, 32'h1);
    chk("R7 a7 data", c_a7wd, 32'h1111);
    xc(1'b0, 1'b1, 12'h804, '0); chk("R7 active isp reads a7", c_rdata, 32'hA700_0000);
    xc(1'b1, 1'b0, 12'h803, 32'h2222); chk("R7 inactive msp no a7 load", {31'b0, c_a7we}, 32'h0);
    xc(1'b0, 1'b1, 12'h803, '0); chk("R7 inactive msp stored", c_rdata, 32'h2222);
    c_m = 1'b1;
    xc(1'b0, 1'b1, 12'h803, '0); chk("R7 active msp reads a7", c_rdata, 32'hA700_0000);
    xc(1'b0, 1'b1, 12'h804, '0); chk("R7 inactive isp stored", c_rdata, 32'h1111);
    xc(1'b1, 1'b0, 12'h803, 32'h3333); chk("R7 msp write loads a7", c_a7wd, 32'h3333);

    // R5 / R1 generation C
    xc(1'b1, 1'b0, 12'h002, 32'hFFFF_FFFF); chk("R5 gen C cache pulse", {31'b0, c_cache}, 32'h1);
    xc(1'b0, 1'b1, 12'h002, '0); chk("R5 gen C cacr masks", c_rdata, 32'h0000_3313);
    xc(1'b0, 1'b1, 12'h003, '0); chk("R1 gen C tcr illegal", {31'b0, c_ill}, 32'h1);
    xc(1'b0, 1'b1, 12'h802, '0); chk("R1 gen C caar legal", {31'b0, c_ill}, 32'h0);
    xc(1'b0, 1'b1, 12'h805, '0); chk("R1 gen C mmusr illegal", {31'b0, c_ill}, 32'h1);
    xc(1'b1, 1'b0, 12'h808, 32'h0); chk("R1 gen C pcr illegal", {31'b0, c_ill}, 32'h1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule